// File: doc/BRIEF.md
# Far-End Alarm Codeword Receiver

This block watches a serial overhead bit stream for the repeating 16-bit far-end alarm codeword. A bit-slot enable qualifies the stream, and the block only takes a bit when that enable is high. On every accepted bit it looks at the most recent 16 bits. A codeword is eight ones, then a zero, then six payload bits, then a closing zero, in the order the bits arrive.

When a candidate appears, the receiver aligns to it and then checks only every sixteenth bit after that. It accepts a payload as valid after three identical codewords in a row. It declares the codeword gone after two incorrect opportunities in a row. Each new validation sets a sticky detect flag and writes the six-bit payload into a four-entry FIFO. If the FIFO is full, that payload is dropped and a sticky overflow flag is set.

The host pops entries with a one-cycle read strobe. It sees the head entry, the fill count and an empty flag. It clears each sticky flag by pulsing a write-one-to-clear input.

Top module: `alarm_cw_rx`

## Requirements
- R1: An accepted bit completes a codeword when the last 16 accepted bits, oldest first, are eight ones, a zero, six payload bits and a zero. The receiver tests this at every bit position while searching.
- R2: A cycle with `bit_en` low changes no state, whatever `bit_in` carries.
- R3: After a first match, opportunities fall every 16 accepted bits. The payload is validated when three consecutive opportunities carry the same payload. A mismatching opportunity before validation drops the candidate. If that opportunity is itself a codeword with another payload, it becomes the new first match.
- R4: Each validation sets `det_flag` and raises `cw_present` on the cycle after the third codeword's last bit. It writes the FIFO once. Further identical codewords write nothing.
- R5: Payload bit 0 is the first payload bit received and bit 5 is the last.
- R6: A validated codeword is declared absent (`cw_present` low) after two consecutive incorrect opportunities. A single incorrect opportunity followed by a correct one clears the miss tally.
- R7: The FIFO holds four payloads, returns them in arrival order, shows the oldest on `fifo_data`, and reports `fifo_count` and `fifo_empty`.
- R8: A validation that meets a full FIFO is discarded, stored entries are kept, and `ovf_flag` is set.
- R9: A `rd_pop` pulse removes one entry. On an empty FIFO it has no effect.
- R10: `clr_det` and `clr_ovf` clear their flags. A set event in the same cycle wins.
- R11: After reset the flags and `cw_present` are low, and the FIFO is empty with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-slot qualifier for `bit_in` |
| bit_in | input | 1 | Serial overhead bit |
| rd_pop | input | 1 | Pops the FIFO head |
| clr_det | input | 1 | Write-one-to-clear for `det_flag` |
| clr_ovf | input | 1 | Write-one-to-clear for `ovf_flag` |
| det_flag | output | 1 | Sticky validation flag |
| ovf_flag | output | 1 | Sticky FIFO overflow flag |
| cw_present | output | 1 | A validated codeword is being received |
| fifo_data | output | 6 | Payload at the FIFO head |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_count | output | 3 | Number of stored payloads |

## Verification
A table of payloads is sent with different repeat counts: one, two, three, four and ten. This separates too few repetitions from exactly enough and from a long run that must not write again. An asymmetric payload shows the bit order. Directed patterns cover the cases that decide the tracking rules:
- a single missing codeword inside a valid run, and then two in a row;
- two copies of one payload followed by another;
- codeword bits spread out by disabled slots carrying zeros;
- five validations against the four-entry FIFO.

// File: rtl/alarm_cw_pkg.sv
package alarm_cw_pkg;
  localparam int CW_LEN   = 16;
  localparam int PAY_W    = 6;
  localparam int PRE_ONES = CW_LEN - PAY_W - 2;

  typedef logic [CW_LEN-1:0] win_t;
  typedef logic [PAY_W-1:0]  pay_t;
  typedef enum logic [1:0] {ST_SEARCH, ST_TRACK, ST_VALID} trk_state_e;

  // window bit CW_LEN-1 is the oldest accepted bit
  function automatic logic cw_match(win_t w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < PRE_ONES; i++) ok &= w[CW_LEN-1-i];
    ok &= ~w[PAY_W+1];
    ok &= ~w[0];
    return ok;
  endfunction

  // first received payload bit lands in bit 0
  function automatic pay_t cw_payload(win_t w);
    pay_t p;
    for (int k = 0; k < PAY_W; k++) p[k] = w[PAY_W-k];
    return p;
  endfunction
endpackage

// File: rtl/alarm_cw_window.sv
module alarm_cw_window
  import alarm_cw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  output win_t win_next
);
  logic [CW_LEN-2:0] hist_q;

  assign win_next = {hist_q, bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n)      hist_q <= '1;
    else if (bit_en) hist_q <= win_next[CW_LEN-2:0];
  end
endmodule

// File: rtl/alarm_cw_track.sv
module alarm_cw_track
  import alarm_cw_pkg::*;
#(
  parameter int VALID_HITS  = 3,
  parameter int LOSS_MISSES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  win_t win_next,
  output logic val_evt,
  output pay_t val_pay,
  output logic present
);
  localparam int HW   = $clog2(VALID_HITS + 1);
  localparam int MW   = $clog2(LOSS_MISSES + 1);
  localparam int CNTW = $clog2(CW_LEN);

  trk_state_e      st_q, st_d;
  pay_t            cand_q, cand_d;
  logic [HW-1:0]   hits_q, hits_d;
  logic [MW-1:0]   miss_q, miss_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  logic hit, same, opp, restart;
  pay_t wpay;

  always_comb begin
    hit     = cw_match(win_next);
    wpay    = cw_payload(win_next);
    same    = (wpay == cand_q);
    opp     = bit_en && (st_q != ST_SEARCH) && (cnt_q == CNTW'(CW_LEN-1));
    st_d    = st_q;
    cand_d  = cand_q;
    hits_d  = hits_q;
    miss_d  = miss_q;
    cnt_d   = cnt_q;
    val_evt = 1'b0;
    restart = 1'b0;
    if (bit_en) begin
      if (st_q != ST_SEARCH) cnt_d = opp ? '0 : cnt_q + CNTW'(1);
      unique case (st_q)
        ST_SEARCH: restart = hit;
        ST_TRACK: if (opp) begin
          if (hit && same) begin
            if (hits_q == HW'(VALID_HITS-1)) begin
              st_d    = ST_VALID;
              miss_d  = '0;
              val_evt = 1'b1;
            end else begin
              hits_d = hits_q + HW'(1);
            end
          end else if (hit) begin
            restart = 1'b1;
          end else begin
            st_d = ST_SEARCH;
          end
        end
        ST_VALID: if (opp) begin
          if (hit && same) begin
            miss_d = '0;
          end else if (miss_q == MW'(LOSS_MISSES-1)) begin
            if (hit) restart = 1'b1;
            else     st_d = ST_SEARCH;
          end else begin
            miss_d = miss_q + MW'(1);
          end
        end
        default: st_d = ST_SEARCH;
      endcase
    end
    if (restart) begin
      st_d   = ST_TRACK;
      cand_d = wpay;
      hits_d = HW'(1);
      cnt_d  = '0;
    end
  end

  assign val_pay = wpay;
  assign present = (st_q == ST_VALID);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_SEARCH;
      cand_q <= '0;
      hits_q <= '0;
      miss_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      cand_q <= cand_d;
      hits_q <= hits_d;
      miss_q <= miss_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/alarm_cw_fifo.sv
module alarm_cw_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 6,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          drop_evt
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign full     = (cnt_q == CW'(DEPTH));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && (cnt_q != '0);
  assign drop_evt = push && full;
  assign head     = mem[rd_q];
  assign count    = cnt_q;
  assign empty    = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= ptr_inc(wr_q);
      if (pop_ok)  rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/alarm_cw_rx.sv
module alarm_cw_rx
  import alarm_cw_pkg::*;
#(
  parameter int VALID_HITS  = 3,
  parameter int LOSS_MISSES = 2,
  parameter int FIFO_DEPTH  = 4,
  localparam int CW         = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             rd_pop,
  input  logic             clr_det,
  input  logic             clr_ovf,
  output logic             det_flag,
  output logic             ovf_flag,
  output logic             cw_present,
  output logic [PAY_W-1:0] fifo_data,
  output logic             fifo_empty,
  output logic [CW-1:0]    fifo_count
);
  win_t win_next;
  logic val_evt, drop_evt;
  pay_t val_pay;
  logic det_q, ovf_q;

  alarm_cw_window win_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .win_next(win_next)
  );

  alarm_cw_track #(.VALID_HITS(VALID_HITS), .LOSS_MISSES(LOSS_MISSES)) trk_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .win_next(win_next),
    .val_evt(val_evt), .val_pay(val_pay), .present(cw_present)
  );

  alarm_cw_fifo #(.DEPTH(FIFO_DEPTH), .W(PAY_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(val_evt), .push_data(val_pay),
    .pop(rd_pop), .head(fifo_data), .count(fifo_count),
    .empty(fifo_empty), .drop_evt(drop_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      det_q <= (det_q & ~clr_det) | val_evt;
      ovf_q <= (ovf_q & ~clr_ovf) | drop_evt;
    end
  end

  assign det_flag = det_q;
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/alarm_cw_rx_chk.sv
module alarm_cw_rx_chk #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          rd_pop,
  input logic          clr_det,
  input logic          val_evt,
  input logic          det_flag,
  input logic          ovf_flag,
  input logic          cw_present,
  input logic          fifo_empty,
  input logic [CW-1:0] fifo_count
);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> !val_evt);
  p_present_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cw_present) |-> $past(val_evt));
  p_det_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag) |-> $past(val_evt));
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));
  p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (val_evt && fifo_count == CW'(DEPTH) && !rd_pop) |=> ($stable(fifo_count) && ovf_flag));
  p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && fifo_empty && !val_evt) |=> (fifo_count == '0));
  p_clear_det_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_det && !val_evt) |=> !det_flag);
endmodule

bind alarm_cw_rx alarm_cw_rx_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rd_pop(rd_pop),
  .clr_det(clr_det), .val_evt(val_evt), .det_flag(det_flag),
  .ovf_flag(ovf_flag), .cw_present(cw_present),
  .fifo_empty(fifo_empty), .fifo_count(fifo_count)
);

// File: tb/alarm_cw_rx_tb_top.sv
module alarm_cw_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam int NVEC       = 6;
  // {payload, repetitions, expect a FIFO write}
  localparam logic [10:0] VEC [NVEC] = '{
    {6'h01, 4'd3,  1'b1},
    {6'h20, 4'd2,  1'b0},
    {6'h2A, 4'd4,  1'b1},
    {6'h00, 4'd1,  1'b0},
    {6'h3F, 4'd10, 1'b1},
    {6'h15, 4'd3,  1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, bit_in = 1'b1, rd_pop = 1'b0, clr_det = 1'b0, clr_ovf = 1'b0;
  logic det_flag, ovf_flag, cw_present, fifo_empty;
  logic [5:0] fifo_data;
  logic [2:0] fifo_count;
  int total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_cw_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .rd_pop(rd_pop), .clr_det(clr_det), .clr_ovf(clr_ovf),
    .det_flag(det_flag), .ovf_flag(ovf_flag), .cw_present(cw_present),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_count(fifo_count)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input bit gap);
    @(negedge clk); bit_en = 1'b1; bit_in = b;
    @(posedge clk); #1 bit_en = 1'b0;
    if (gap) begin
      bit_in = 1'b0;
      @(posedge clk); #1;
    end
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0);
  endtask

  // eight ones, zero, payload bit 0 first, zero
  task automatic send_cw(input logic [5:0] p, input bit gap);
    for (int i = 0; i < 8; i++) send_bit(1'b1, gap);
    send_bit(1'b0, gap);
    for (int k = 0; k < 6; k++) send_bit(p[k], gap);
    send_bit(1'b0, gap);
  endtask

  task automatic send_n(input logic [5:0] p, input int n);
    for (int i = 0; i < n; i++) send_cw(p, 1'b0);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) rd_pop = 1'b1;
    else if (which == 1) clr_det = 1'b1;
    else clr_ovf = 1'b1;
    @(posedge clk); #1 rd_pop = 1'b0; clr_det = 1'b0; clr_ovf = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", WD_CYCLES);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    check("R11 count", fifo_count, 0);
    check("R11 empty", fifo_empty, 1);
    check("R11 det", det_flag, 0);
    check("R11 ovf", ovf_flag, 0);
    check("R11 present", cw_present, 0);
    ones(20);

    // table walk: R1 R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0] p;
      int reps;
      bit exp;
      p = VEC[v][10:5]; reps = int'(VEC[v][4:1]); exp = VEC[v][0];
      send_n(p, reps);
      check("R3 present after run", cw_present, int'(exp));
      check("R4 one write per validation", fifo_count, int'(exp));
      ones(32);
      check("R6 absent after two misses", cw_present, 0);
      if (exp) begin
        check("R5 payload order", fifo_data, p);
        pulse(0);
        check("R9 pop", fifo_empty, 1);
      end
    end
    check("R4 det set", det_flag, 1);
    pulse(1);
    check("R10 det cleared", det_flag, 0);

    // R3 candidate replaced by a different codeword
    send_n(6'h0B, 2);
    send_n(6'h34, 3);
    check("R3 switch count", fifo_count, 1);
    check("R3 switch data", fifo_data, 6'h34);
    ones(32); pulse(0);

    // R6 single miss recovery
    send_n(6'h19, 3);
    ones(16); send_cw(6'h19, 1'b0);
    ones(16); send_cw(6'h19, 1'b0);
    check("R6 still present", cw_present, 1);
    check("R6 no rewrite", fifo_count, 1);
    ones(32);
    check("R6 lost", cw_present, 0);
    send_n(6'h19, 3);
    check("R6 revalidated", fifo_count, 2);
    ones(32); pulse(0); pulse(0);

    // R2 disabled slots carrying zeros
    for (int i = 0; i < 3; i++) send_cw(6'h26, 1'b1);
    check("R2 gapped count", fifo_count, 1);
    check("R2 gapped data", fifo_data, 6'h26);
    ones(32); pulse(0);

    // R8 overflow
    for (int i = 0; i < 5; i++) begin
      send_n(6'(i + 3), 3);
      ones(32);
    end
    check("R8 count held", fifo_count, 4);
    check("R8 ovf set", ovf_flag, 1);
    for (int i = 0; i < 4; i++) begin
      check("R7 order", fifo_data, i + 3);
      pulse(0);
    end
    check("R7 empty", fifo_empty, 1);
    pulse(0);
    check("R9 pop on empty", fifo_count, 0);
    pulse(2);
    check("R10 ovf cleared", ovf_flag, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule